// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the processor-facing side of an eight-input interrupt controller. A processor reaches it through a two-location byte port chosen by one address bit. Before the controller can be used, the processor runs a short initialization sequence. A starting word goes to the low address, and up to three further words follow at the high address. Some of those later words are skipped, depending on what the starting word asked for. The block stores the resulting configuration and presents it as steady outputs.

Once initialization is over, the block works as a command decoder. High-address writes and reads reach the mask register. A low-address write either issues an end-of-interrupt or priority command, or changes what the next low-address read returns. End-of-interrupt and priority commands are passed to a separate priority core as a one-cycle strobe with an operation code and a level. Read selection covers the request register, the in-service register, or a single poll word. The request, in-service and poll values are inputs that the priority core supplies; this block only routes them to the read port.

Top module: `picif_regs`

## Requirements
- R1: A write to the low address with bit 4 = 1 is a start word. It is accepted in every state, and it drops `init_done` and opens a new sequence, so that the next high-address write is taken as the vector word.
- R2: The start word stores four fields. Bit 0 = 1 means a fourth word will follow. Bit 1 = 1 selects single mode (`single_mode`). Bit 2 = 1 selects 4-byte spacing (`spacing4`). Bit 3 = 1 selects level triggering (`level_trig`).
- R3: Within a sequence, the first high-address write loads `vec_base` from bits 7..3. The slave-map word is expected only when single mode is off. The fourth word is expected only when start-word bit 0 was 1. `init_done` goes to 1 on the last expected word.
- R4: The slave-map word loads `slave_map` as written, with bit n = 1 meaning input n has a slave attached. A start word clears `slave_map` to 0.
- R5: The fourth word sets four outputs: `mode86` from bit 0, `auto_eoi` from bit 1, `buf_mode` from bits 3..2 (10 is buffered slave, 11 is buffered master), and `sfnm` from bit 4. A start word clears all of these to 0, so they stay 0 when no fourth word is expected.
- R6: A start word has four side effects. It clears `mask` to 0. It selects the request register for low-address reads. It cancels any pending poll and clears `spec_mask`. It pulses `prio_rst` for exactly one cycle.
- R7: While `init_done` = 1, a high-address write loads `mask`. A high-address read always returns `mask` on `rdata`.
- R8: While `init_done` = 1, a low-address write with bit 4 = 0 and bit 3 = 0 drives `cmd_stb` high for the single cycle after the write. During that cycle, `cmd_op` carries bits 7..5 and `cmd_lvl` carries bits 2..0.
- R9: While `init_done` = 1, a low-address write with bit 4 = 0 and bit 3 = 1 sets the read selection from bits 1..0. The value 10 selects `irr_in` and 11 selects `isr_in`. The values 00 and 01 keep the previous selection. A low-address read returns the selected input.
- R10: In that same word, bit 2 = 1 arms a poll. The next low-address read returns `poll_word`, and only that read does so. Later reads return the selected register again.
- R11: In that same word, bits 6..5 control special mask. The value 11 sets `spec_mask`, 10 clears it, and 00 or 01 leave it unchanged.
- R12: While `init_done` = 0, low-address writes with bit 4 = 0 have no effect: no strobe and no change in read selection or special mask. High-address writes go only to the sequence words and leave `mask` unchanged.
- R13: After reset, every configuration output, `mask`, `spec_mask`, `cmd_stb`, `prio_rst` and `init_done` is 0. Until a start word arrives, high-address writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (a low-address read consumes a pending poll) |
| addr | input | 1 | Port select: 0 low, 1 high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and selection |
| irr_in | input | 8 | Request register from the priority core |
| isr_in | input | 8 | In-service register from the priority core |
| poll_word | input | 8 | Poll result from the priority core |
| init_done | output | 1 | Initialization sequence complete |
| vec_base | output | 5 | Vector base bits 7..3 |
| spacing4 | output | 1 | 4-byte vector spacing |
| level_trig | output | 1 | Level-triggered inputs |
| single_mode | output | 1 | No cascade |
| slave_map | output | 8 | Inputs with a slave attached |
| mode86 | output | 1 | 86/88 processor mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| buf_mode | output | 2 | Buffered mode code |
| sfnm | output | 1 | Special fully nested mode |
| mask | output | 8 | Interrupt mask, 1 disables the input |
| prio_rst | output | 1 | One-cycle pulse: reset priority order |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command operation code |
| cmd_lvl | output | 3 | Command level |
| spec_mask | output | 1 | Special mask mode active |

## Verification
The hardest situation to reach is a start word that arrives partway through a sequence. It must reset the skip decisions so that a new combination of optional words applies. The stimulus aborts a cascade sequence while it waits for the slave-map word, then reruns initialization in single mode with a fourth word. It checks that the next two high-address writes land as vector and fourth word rather than as slave map. A second hard case is a poll combined with a read-selection change in the same command. The stimulus shows that exactly one read returns the poll word and that the following read falls back to the newly chosen register.

// File: rtl/picif_pkg.sv
package picif_pkg;
  localparam int BYTE_W = 8;
  localparam int LVL_W  = $clog2(BYTE_W);
  localparam int BASE_W = BYTE_W - 3;

  typedef enum logic [2:0] {
    ST_UNINIT, ST_ICW2, ST_ICW3, ST_ICW4, ST_READY
  } seq_t;

  typedef enum logic [1:0] {
    LK_START, LK_CMD, LK_RDSEL
  } lowkind_t;

  // what a low-address byte means, from bits 4 and 3
  function automatic lowkind_t classify_low(input logic [BYTE_W-1:0] d);
    if (d[4])      return LK_START;
    else if (d[3]) return LK_RDSEL;
    else           return LK_CMD;
  endfunction

  function automatic seq_t after_vector(input logic single, input logic want4);
    if (!single)    return ST_ICW3;
    else if (want4) return ST_ICW4;
    else            return ST_READY;
  endfunction

  function automatic seq_t after_slave(input logic want4);
    return want4 ? ST_ICW4 : ST_READY;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_read(
      input logic hi, input logic poll, input logic isr_sel,
      input logic [BYTE_W-1:0] msk, input logic [BYTE_W-1:0] pw,
      input logic [BYTE_W-1:0] isr, input logic [BYTE_W-1:0] irr);
    if (hi)           return msk;
    else if (poll)    return pw;
    else if (isr_sel) return isr;
    else              return irr;
  endfunction
endpackage

// File: rtl/picif_icw_seq.sv
module picif_icw_seq
  import picif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic              ready,
  output logic [BASE_W-1:0] vec_base,
  output logic              spacing4,
  output logic              level_trig,
  output logic              single_mode,
  output logic [BYTE_W-1:0] slave_map,
  output logic              mode86,
  output logic              auto_eoi,
  output logic [1:0]        buf_mode,
  output logic              sfnm,
  output logic              prio_rst
);
  seq_t state;
  logic want4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_UNINIT; want4 <= 1'b0; vec_base <= '0;
      spacing4 <= 1'b0; level_trig <= 1'b0; single_mode <= 1'b0;
      slave_map <= '0; mode86 <= 1'b0; auto_eoi <= 1'b0;
      buf_mode <= 2'b00; sfnm <= 1'b0; prio_rst <= 1'b0;
    end else begin
      prio_rst <= 1'b0;
      if (ev_start) begin
        state       <= ST_ICW2;
        want4       <= wdata[0];
        single_mode <= wdata[1];
        spacing4    <= wdata[2];
        level_trig  <= wdata[3];
        slave_map   <= '0;
        mode86 <= 1'b0; auto_eoi <= 1'b0; buf_mode <= 2'b00; sfnm <= 1'b0;
        prio_rst    <= 1'b1;
      end else if (wr_hi) begin
        case (state)
          ST_ICW2: begin
            vec_base <= wdata[BYTE_W-1:3];
            state    <= after_vector(single_mode, want4);
          end
          ST_ICW3: begin
            slave_map <= wdata;
            state     <= after_slave(want4);
          end
          ST_ICW4: begin
            mode86   <= wdata[0];
            auto_eoi <= wdata[1];
            buf_mode <= wdata[3:2];
            sfnm     <= wdata[4];
            state    <= ST_READY;
          end
          default: ;
        endcase
      end
    end
  end

  assign ready = (state == ST_READY);

  p_start_opens_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state == ST_ICW2) && !ready);
  p_cascade_wants_slave_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ICW2 && wr_hi && !ev_start && !single_mode) |=> state == ST_ICW3);
  p_skip_to_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ICW2 && wr_hi && !ev_start && single_mode && !want4) |=> ready);
  p_prio_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prio_rst |-> $past(ev_start));
  p_uninit_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UNINIT && !ev_start) |=> state == ST_UNINIT);
endmodule

// File: rtl/picif_ocw_dec.sv
module picif_ocw_dec
  import picif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_cmd,
  input  logic              ev_rdsel,
  input  logic              ev_mask,
  input  logic              ev_rd_lo,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] mask,
  output logic              cmd_stb,
  output logic [2:0]        cmd_op,
  output logic [LVL_W-1:0]  cmd_lvl,
  output logic              isr_sel,
  output logic              poll_pend,
  output logic              spec_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0; cmd_stb <= 1'b0; cmd_op <= '0; cmd_lvl <= '0;
      isr_sel <= 1'b0; poll_pend <= 1'b0; spec_mask <= 1'b0;
    end else begin
      cmd_stb <= ev_cmd;
      if (ev_cmd) begin
        cmd_op  <= wdata[7:5];
        cmd_lvl <= wdata[LVL_W-1:0];
      end
      if (ev_start) begin
        mask <= '0; isr_sel <= 1'b0; poll_pend <= 1'b0; spec_mask <= 1'b0;
      end else begin
        if (ev_mask) mask <= wdata;
        if (ev_rdsel && wdata[1]) isr_sel   <= wdata[0];
        if (ev_rdsel && wdata[6]) spec_mask <= wdata[5];
        if (ev_rdsel && wdata[2]) poll_pend <= 1'b1;
        else if (ev_rd_lo)        poll_pend <= 1'b0;
      end
    end
  end

  p_start_clears_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> mask == '0);
  p_mask_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_mask && !ev_start) |=> $stable(mask));
  p_cmd_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(ev_cmd));
  p_poll_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_pend && ev_rd_lo && !ev_rdsel && !ev_start) |=> !poll_pend);
  p_smm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rdsel && !ev_start) |=> $stable(spec_mask));
endmodule

// File: rtl/picif_regs.sv
module picif_regs
  import picif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] irr_in,
  input  logic [BYTE_W-1:0] isr_in,
  input  logic [BYTE_W-1:0] poll_word,
  output logic              init_done,
  output logic [BASE_W-1:0] vec_base,
  output logic              spacing4,
  output logic              level_trig,
  output logic              single_mode,
  output logic [BYTE_W-1:0] slave_map,
  output logic              mode86,
  output logic              auto_eoi,
  output logic [1:0]        buf_mode,
  output logic              sfnm,
  output logic [BYTE_W-1:0] mask,
  output logic              prio_rst,
  output logic              cmd_stb,
  output logic [2:0]        cmd_op,
  output logic [LVL_W-1:0]  cmd_lvl,
  output logic              spec_mask
);
  lowkind_t kind;
  logic wr_lo, wr_hi, ev_start, ev_cmd, ev_rdsel, ev_mask, ev_rd_lo;
  logic isr_sel, poll_pend;

  assign kind     = classify_low(wdata);
  assign wr_lo    = wr_en && !addr;
  assign wr_hi    = wr_en && addr;
  assign ev_start = wr_lo && (kind == LK_START);
  assign ev_cmd   = wr_lo && (kind == LK_CMD)   && init_done;
  assign ev_rdsel = wr_lo && (kind == LK_RDSEL) && init_done;
  assign ev_mask  = wr_hi && init_done;
  assign ev_rd_lo = rd_en && !addr;

  picif_icw_seq u_seq (
    .clk, .rst_n, .ev_start, .wr_hi, .wdata,
    .ready(init_done), .vec_base, .spacing4, .level_trig, .single_mode,
    .slave_map, .mode86, .auto_eoi, .buf_mode, .sfnm, .prio_rst
  );

  picif_ocw_dec u_ocw (
    .clk, .rst_n, .ev_start, .ev_cmd, .ev_rdsel, .ev_mask, .ev_rd_lo, .wdata,
    .mask, .cmd_stb, .cmd_op, .cmd_lvl, .isr_sel, .poll_pend, .spec_mask
  );

  assign rdata = pick_read(addr, poll_pend, isr_sel, mask, poll_word, isr_in, irr_in);

  p_no_cmd_uninit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !init_done && kind != LK_START) |=> !cmd_stb);
  p_hi_read_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr |-> rdata == mask);
endmodule

// File: tb/sim_picif_regs.sv
module sim_picif_regs;
  localparam int PERIOD = 10;
  localparam logic [7:0] IRR = 8'hA5, ISR = 8'h3C, PW = 8'h83;
  localparam int NT = 15;
  // {op: 0 write / 1 read-compare, addr, data, expected}
  localparam logic [17:0] TBL [NT] = '{
    {1'b0,1'b1,8'h5A,8'h00}, {1'b1,1'b1,8'h00,8'h5A},
    {1'b1,1'b0,8'h00,8'hA5},
    {1'b0,1'b0,8'h0B,8'h00}, {1'b1,1'b0,8'h00,8'h3C},
    {1'b0,1'b0,8'h09,8'h00}, {1'b1,1'b0,8'h00,8'h3C},
    {1'b0,1'b0,8'h0A,8'h00}, {1'b1,1'b0,8'h00,8'hA5},
    {1'b0,1'b0,8'h0C,8'h00}, {1'b1,1'b0,8'h00,8'h83},
    {1'b1,1'b0,8'h00,8'hA5},
    {1'b0,1'b0,8'h0F,8'h00}, {1'b1,1'b0,8'h00,8'h83},
    {1'b1,1'b0,8'h00,8'h3C}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata, slave_map, mask;
  logic init_done, spacing4, level_trig, single_mode, mode86, auto_eoi, sfnm;
  logic prio_rst, cmd_stb, spec_mask;
  logic [4:0] vec_base;
  logic [1:0] buf_mode;
  logic [2:0] cmd_op, cmd_lvl;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  picif_regs u0 (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .irr_in(IRR), .isr_in(ISR), .poll_word(PW),
    .init_done, .vec_base, .spacing4, .level_trig, .single_mode, .slave_map,
    .mode86, .auto_eoi, .buf_mode, .sfnm, .mask, .prio_rst,
    .cmd_stb, .cmd_op, .cmd_lvl, .spec_mask
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state; high write ignored before any start word
    chk("R13 init_done", init_done, 0);
    chk("R13 cmd_stb", cmd_stb, 0);
    wr(1'b1, 8'hFF);
    chk("R13 mask after early write", mask, 0);
    chk("R13 vec_base", vec_base, 0);
    rd(1'b1, v); chk("R13 rdata hi", v, 0);

    // single mode, no fourth word
    wr(1'b0, 8'h16);
    chk("R1 init_done drop", init_done, 0);
    chk("R6 prio_rst pulse", prio_rst, 1);
    chk("R2 single", single_mode, 1);
    chk("R2 spacing4", spacing4, 1);
    chk("R2 level", level_trig, 0);
    wr(1'b1, 8'h48);
    chk("R3 vec_base", vec_base, 5'd9);
    chk("R3 done after vector", init_done, 1);
    chk("R5 no fourth word", {mode86, auto_eoi, buf_mode, sfnm}, 0);
    chk("R4 slave map single", slave_map, 0);
    wr(1'b1, 8'hF0);
    chk("R7 mask load", mask, 8'hF0);

    // cascade with fourth word
    wr(1'b0, 8'h19);
    chk("R6 mask cleared", mask, 0);
    chk("R2 level set", level_trig, 1);
    chk("R2 cascade", single_mode, 0);
    wr(1'b1, 8'h70);
    chk("R3 vec_base 2", vec_base, 5'h0E);
    chk("R3 waits slave", init_done, 0);
    chk("R12 mask untouched", mask, 0);
    wr(1'b1, 8'h04);
    chk("R4 slave map", slave_map, 8'h04);
    chk("R3 waits fourth", init_done, 0);
    wr(1'b0, 8'h20);
    chk("R12 no strobe in init", cmd_stb, 0);
    wr(1'b0, 8'h68);
    chk("R12 no smm in init", spec_mask, 0);
    wr(1'b1, 8'h1F);
    chk("R5 fields", {sfnm, buf_mode, auto_eoi, mode86}, 5'b11111);
    chk("R3 done", init_done, 1);

    // R8 command strobe
    wr(1'b0, 8'h65);
    chk("R8 strobe", cmd_stb, 1);
    chk("R8 op", cmd_op, 3'd3);
    chk("R8 level", cmd_lvl, 3'd5);
    @(negedge clk);
    chk("R8 strobe single cycle", cmd_stb, 0);

    // R11 special mask
    wr(1'b0, 8'h68); chk("R11 set", spec_mask, 1);
    wr(1'b0, 8'h28); chk("R11 keep", spec_mask, 1);
    wr(1'b0, 8'h48); chk("R11 clear", spec_mask, 0);

    // table: R7 mask access, R9 read select, R10 poll
    for (int i = 0; i < NT; i++) begin
      if (TBL[i][17] == 1'b0) wr(TBL[i][16], TBL[i][15:8]);
      else begin
        rd(TBL[i][16], v);
        chk($sformatf("R7/R9/R10 table step %0d", i), v, TBL[i][7:0]);
      end
    end

    // R1 restart while waiting for the slave-map word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h08);
    chk("R1 mid waits slave", init_done, 0);
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h20);
    chk("R1 restart vector", vec_base, 5'd4);
    chk("R1 still waiting fourth", init_done, 0);
    chk("R4 slave map cleared", slave_map, 0);
    wr(1'b1, 8'h01);
    chk("R1 restart fourth", {init_done, mode86, auto_eoi}, 3'b110);
    rd(1'b0, v); chk("R6 read select back to request", v, IRR);

    finish_run();
  end
endmodule